// File: doc/BRIEF.md
# Serial Servo Frame Decoder

This block recovers proportional and switched commands from a serial radio-control frame. Its input is a carrier-present level that has already been demodulated. A carrier dropout marks the start of each slot. The decoder counts these dropouts, so each slot is a short fixed-width carrier-off gap followed by a carrier-on interval of variable length. While the slot count is 1 or 2, the matching servo output is driven high. Each servo pulse therefore lasts for one gap plus one variable interval, and its width follows the transmitter's stick position.

After the two proportional slots, the transmitter sends between one and four more fixed-width slots. These extra slots carry no servo information. What matters is how many there are. The frame ends with a carrier-on interval longer than a programmable timeout. When the decoder sees that long interval, it copies the two low bits of the dropout count into two switched outputs. It then clears the counter, ready for the next frame. All times are measured in clock ticks.

Top module: `rc_frame_decoder`

## Requirements
- R1: The input passes through a two-flop synchroniser. A 3-bit slot count increases by one for each carrier-off transition (1 to 0) of the synchronised input. A transition from 0 to 1 never changes the count.
- R2: `servo1_o` is high exactly while the count is 1. Its pulse width in clock cycles equals the first carrier-off gap plus the first carrier-on interval.
- R3: `servo2_o` is high exactly while the count is 2. Its pulse width equals the second gap plus the second carrier-on interval.
- R4: Slots counted after the second one (count 3 or more) produce no pulse on either servo output.
- R5: The sync timer is held at zero while the carrier is off. A frame end is detected only when a single carrier-on interval lasts longer than `SYNC_TICKS` cycles. An interval of exactly `SYNC_TICKS` cycles is treated as an ordinary slot.
- R6: On a frame end, count bit 0 goes to `dig_a_o` and count bit 1 goes to `dig_b_o`. Final counts 4, 5, 6 and 7 give A/B of 0/0, 1/0, 0/1 and 1/1.
- R7: A frame end starts a load window of `PULSE_TICKS` cycles. A clear window of the same length follows it and returns the count to 0, so the next frame is decoded from zero.
- R8: Between frame ends, the switched outputs keep their last loaded value.
- R9: The count wraps silently from 7 to 0. Eight dropouts in a frame give A/B = 0/0, and nine give A/B = 1/0.
- R10: While `rst_n` is low, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| carrier_i | input | 1 | Demodulated carrier-present level (1 = carrier on) |
| servo1_o | output | 1 | First proportional pulse |
| servo2_o | output | 1 | Second proportional pulse |
| dig_a_o | output | 1 | Switched output A (count bit 0) |
| dig_b_o | output | 1 | Switched output B (count bit 1) |

## Verification
The assertions assume a well-formed carrier pattern. Every carrier-on interval is either at most `SYNC_TICKS` cycles long, or long enough to cover both the load window and the clear window before the next dropout. A dropout that arrives while the counter is being cleared would be lost, and the properties do not cover that case. The stimulus draws slot widths only up to the timeout and gap lengths of a few cycles. Every frame end is held well past detection plus both windows. Directed frames exercise intervals of exactly the timeout and counts that wrap past 7.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_LOAD  = 2'd1,
    SEQ_CLEAR = 2'd2
  } seq_state_t;
endpackage

// File: rtl/rcd_input_sync.sv
module rcd_input_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  output logic level_o,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din_i};
    prev_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign fall_o  = prev_q & ~level_o;
  assign rise_o  = ~prev_q & level_o;

  // R1
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chain_q[0]) == chain_q[STAGES-1] || STAGES != 2);
endmodule

// File: rtl/rcd_slot_counter.sv
module rcd_slot_counter #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  input  logic         rise_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] TOP_V = '1;

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (adv_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R1
  cnt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> ($past(adv_i) || $past(clr_i)));
  // R1
  rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && !clr_i) |=> (cnt_q == $past(cnt_q)));
  // R9
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !clr_i && cnt_q == TOP_V) |=> (cnt_q == '0));
endmodule

// File: rtl/rcd_sync_timer.sv
module rcd_sync_timer #(
  parameter int LIMIT = 700000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic fire_o
);
  localparam int TW = $clog2(LIMIT + 2);
  localparam logic [TW-1:0] LIM_V = TW'(LIMIT);
  localparam logic [TW-1:0] SAT_V = TW'(LIMIT + 1);

  logic [TW-1:0] tmr_q, tmr_d;

  always_comb begin
    tmr_d = tmr_q;
    if (!level_i)           tmr_d = '0;
    else if (tmr_q != SAT_V) tmr_d = tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  assign fire_o = level_i && (tmr_q == LIM_V);

  // R5
  tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !level_i |=> (tmr_q == '0));
  // R5
  fire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);
endmodule

// File: rtl/rcd_read_seq.sv
module rcd_read_seq
  import rcd_pkg::*;
#(
  parameter int PULSE = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire_i,
  input  logic [1:0] bits_i,
  output logic       load_o,
  output logic       clr_o,
  output logic       dig_a_o,
  output logic       dig_b_o
);
  localparam int PW = (PULSE > 1) ? $clog2(PULSE) : 1;
  localparam logic [PW-1:0] LAST_V = PW'(PULSE - 1);

  seq_state_t    st_q, st_d;
  logic [PW-1:0] pc_q, pc_d;
  logic [1:0]    dig_q, dig_d;
  logic          last_w;

  assign last_w = (pc_q == LAST_V);

  always_comb begin
    st_d = st_q;
    pc_d = pc_q;
    unique case (st_q)
      SEQ_IDLE: begin
        pc_d = '0;
        if (fire_i) st_d = SEQ_LOAD;
      end
      SEQ_LOAD: begin
        if (last_w) begin
          st_d = SEQ_CLEAR;
          pc_d = '0;
        end else begin
          pc_d = pc_q + 1'b1;
        end
      end
      SEQ_CLEAR: begin
        if (last_w) begin
          st_d = SEQ_IDLE;
          pc_d = '0;
        end else begin
          pc_d = pc_q + 1'b1;
        end
      end
      default: begin
        st_d = SEQ_IDLE;
        pc_d = '0;
      end
    endcase
  end

  always_comb begin
    dig_d = dig_q;
    if (st_q == SEQ_LOAD) dig_d = bits_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      pc_q  <= '0;
      dig_q <= '0;
    end else begin
      st_q  <= st_d;
      pc_q  <= pc_d;
      dig_q <= dig_d;
    end
  end

  assign load_o  = (st_q == SEQ_LOAD);
  assign clr_o   = (st_q == SEQ_CLEAR);
  assign dig_a_o = dig_q[0];
  assign dig_b_o = dig_q[1];

  // R7
  clear_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_o) |-> $past(load_o));
  // R7
  load_needs_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_o) |-> $past(fire_i));
  // R8
  dig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_q != $past(dig_q)) |-> $past(load_o));
endmodule

// File: rtl/rc_frame_decoder.sv
module rc_frame_decoder #(
  parameter int SYNC_TICKS  = 700000,
  parameter int PULSE_TICKS = 2000,
  parameter int CNT_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic carrier_i,
  output logic servo1_o,
  output logic servo2_o,
  output logic dig_a_o,
  output logic dig_b_o
);
  localparam logic [CNT_W-1:0] SLOT1_V = CNT_W'(1);
  localparam logic [CNT_W-1:0] SLOT2_V = CNT_W'(2);

  logic             lvl_w, fall_w, rise_w;
  logic             fire_w, load_w, clr_w;
  logic [CNT_W-1:0] cnt_w;

  rcd_input_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din_i(carrier_i),
    .level_o(lvl_w), .fall_o(fall_w), .rise_o(rise_w)
  );

  rcd_slot_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .adv_i(fall_w), .rise_i(rise_w),
    .clr_i(clr_w), .cnt_o(cnt_w)
  );

  rcd_sync_timer #(.LIMIT(SYNC_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .level_i(lvl_w), .fire_o(fire_w)
  );

  rcd_read_seq #(.PULSE(PULSE_TICKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .fire_i(fire_w), .bits_i(cnt_w[1:0]),
    .load_o(load_w), .clr_o(clr_w), .dig_a_o(dig_a_o), .dig_b_o(dig_b_o)
  );

  assign servo1_o = (cnt_w == SLOT1_V);
  assign servo2_o = (cnt_w == SLOT2_V);

  // R3
  servo_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(servo1_o) |-> (servo2_o || $past(clr_w)));
  // R2
  servo1_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(servo1_o) |-> $past(fall_w));
  // R4
  servo2_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(servo2_o) |-> $past(servo1_o));
endmodule

// File: tb/rc_frame_decoder_bench.sv
`timescale 1ns/1ps
module rc_frame_decoder_bench;
  localparam int SYNC_T   = 40;
  localparam int PULSE_T  = 3;
  localparam int SYNC_LEN = 70;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic carrier = 1'b1;
  logic servo1, servo2, dig_a, dig_b;

  int checks = 0;
  int errors = 0;
  int h1, h2;
  int wid [0:15];
  int exp_a = 0;
  int exp_b = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rc_frame_decoder #(.SYNC_TICKS(SYNC_T), .PULSE_TICKS(PULSE_T)) u_rc_frame_decoder (
    .clk(clk), .rst_n(rst_n), .carrier_i(carrier),
    .servo1_o(servo1), .servo2_o(servo2), .dig_a_o(dig_a), .dig_b_o(dig_b)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input bit v, input int n);
    repeat (n) begin
      @(negedge clk);
      if (servo1) h1++;
      if (servo2) h2++;
      carrier = v;
    end
  endtask

  // One frame: nch slots, then a final gap and a long sync interval.
  task automatic frame(input int nch, input int g, input int slen, input bit chk_servo);
    int falls;
    h1 = 0;
    h2 = 0;
    hold(1'b0, g);
    check("R8 A held between frames", int'(dig_a), exp_a);
    check("R8 B held between frames", int'(dig_b), exp_b);
    hold(1'b1, wid[0]);
    for (int i = 1; i < nch; i++) begin
      hold(1'b0, g);
      hold(1'b1, wid[i]);
    end
    hold(1'b0, g);
    hold(1'b1, slen);
    falls = nch + 1;
    if (chk_servo) begin
      check("R2 servo1 width", h1, g + wid[0]);
      check("R3/R4 servo2 width, no extra pulses", h2, g + wid[1]);
    end
    exp_a = falls % 2;
    exp_b = (falls / 2) % 2;
    check("R6/R9 dig A", int'(dig_a), exp_a);
    check("R6/R9 dig B", int'(dig_b), exp_b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    repeat (4) @(negedge clk);
    // R10 reset state
    check("R10 servo1 in reset", int'(servo1), 0);
    check("R10 servo2 in reset", int'(servo2), 0);
    check("R10 dig A in reset", int'(dig_a), 0);
    check("R10 dig B in reset", int'(dig_b), 0);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    check("R8 idle sync keeps A off", int'(dig_a), 0);
    check("R8 idle sync keeps B off", int'(dig_b), 0);

    // R6 all four codes, R1/R7 via servo widths
    for (int n = 3; n <= 6; n++) begin
      for (int i = 0; i < 16; i++) wid[i] = 10 + 3 * i;
      frame(n, 5, SYNC_LEN, 1'b1);
    end
    // R5 intervals of exactly the timeout are ordinary slots
    for (int i = 0; i < 16; i++) wid[i] = SYNC_T;
    frame(6, 4, SYNC_LEN, 1'b1);
    frame(3, 6, SYNC_LEN, 1'b1);
    // R5/R7 shortest sync that still completes load and clear
    for (int i = 0; i < 16; i++) wid[i] = 12;
    frame(4, 5, SYNC_T + 2 * PULSE_T + 2, 1'b1);
    frame(5, 5, SYNC_LEN, 1'b1);
    // R9 wrap
    frame(7, 4, SYNC_LEN, 1'b1);
    frame(8, 4, SYNC_LEN, 1'b0);
    frame(3, 4, SYNC_LEN, 1'b1);

    // random frames
    for (int f = 0; f < 24; f++) begin
      int nch;
      int g;
      nch = 3 + int'($urandom_range(3, 0));
      g = 4 + int'($urandom_range(4, 0));
      for (int i = 0; i < 16; i++) wid[i] = 8 + int'($urandom_range(SYNC_T - 8, 0));
      frame(nch, g, SYNC_LEN, 1'b1);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule